// File: doc/BRIEF.md
# Passive SPI FPGA configuration sequencer

This block sits on the host side of a board and loads a bitstream into the configuration memory of a target FPGA that is strapped for passive serial loading. On a start command it pulls the target's chip select low and keeps it low for the whole load. It then pulses the target's active-low reset and waits a fixed settle time. Next it shifts the bitstream out over an SPI clock and data pair in mode 3, most significant bit first. After the data it sends a run of zero bytes so that the target sees more than a hundred extra clocks.

Bitstream bytes arrive on a valid/ready byte stream with a last-byte flag. Once the trailing clocks are sent, the sequencer can poll the target's configuration-done pin, with a programmable timeout. When the pin rises it waits a further fixed time before it reports completion. All delays are counted in system-clock cycles and are set by parameters. A request flagged as partial reconfiguration is refused at once and no pin moves.

Top module: `spi_cfg_loader`

## Requirements
- R1: Chip select (`cs_n`) is low in every cycle in which `busy` is high. It is high whenever the sequencer is idle, including after completion and after any error.
- R2: Chip select goes low at least one cycle before `creset_n` falls. `creset_n` then stays low for exactly RST_LOW_CYC clock cycles.
- R3: At least SETTLE_CYC clock cycles pass between the rise of `creset_n` and the first falling edge of `sclk`.
- R4: Data uses SPI mode 3: `sclk` is high whenever chip select is high and between bytes, and `mosi` changes only together with a falling `sclk` edge. Each bit is sampled on the rising edge, bit 7 first, and each clock phase lasts HALF_DIV cycles.
- R5: Bytes appear on `mosi` in stream order. The byte accepted with `s_last` high is the last data byte, and this holds even when it is the first byte.
- R6: `s_ready` is low while a byte is being shifted. It is high only in the data phase, when the shifter is idle and the last byte has not yet been taken.
- R7: After the last data byte exactly IDLE_BYTES zero bytes follow. With the default of 13 this gives 104 extra rising clocks, and a load of N data bytes gives 8*(N+13) rising edges in total.
- R8: With `done_en` high, if the synchronised `cdone_i` stays low for timeout_lim+1 cycles of polling, `err_timeout` is set, `done` stays low and the sequencer returns to idle.
- R9: With `done_en` high, `done` rises exactly USER_CYC+3 cycles after `cdone_i` rises during polling. This is a two-stage synchroniser, one decision cycle and USER_CYC cycles of wait.
- R10: A start with `partial_req` high sets `err_refused`, leaves `busy` low and leaves `cs_n`, `creset_n` and `sclk` unchanged.
- R11: With `done_en` low, polling is skipped. `done` rises USER_CYC plus at most HALF_DIV+3 cycles after the last trailing bit is clocked, whatever `cdone_i` does.
- R12: `tgt_operating` is high only while `done_en` is high and the synchronised `cdone_i` is high.
- R13: After reset, `cs_n`, `creset_n` and `sclk` are high and `busy`, `done` and `s_ready` are low. Every start command clears `done` and both error flags, and an accepted start raises `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (sampled only while idle) |
| partial_req | input | 1 | Request is partial reconfiguration (refused) |
| done_en | input | 1 | Configuration-done pin is connected and polled |
| timeout_lim | input | CNT_W | Polling limit in clock cycles |
| s_data | input | 8 | Bitstream byte |
| s_valid | input | 1 | Stream byte valid |
| s_last | input | 1 | Stream byte is the final one |
| s_ready | output | 1 | Stream byte accepted when high with valid |
| cs_n | output | 1 | Target chip select, active low |
| creset_n | output | 1 | Target reset, active low |
| sclk | output | 1 | SPI clock, idles high |
| mosi | output | 1 | SPI serial data to target |
| cdone_i | input | 1 | Target configuration-done pin (asynchronous) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last load completed and user-mode wait elapsed |
| err_timeout | output | 1 | Configuration-done never rose within the limit |
| err_refused | output | 1 | Last request was refused |
| tgt_operating | output | 1 | Target reports configured |

## Verification
The bench rebuilds every byte from the rising `sclk` edges and compares it with a queue of expected data followed by the zero tail. A design that sampled on the wrong edge, sent the low bit first or got the tail length wrong therefore shows miscompares or a wrong edge count. It measures the reset pulse width, the gap between reset release and the first clock, and the exact delay from `cdone_i` to `done`. This catches off-by-one counters and a missing synchroniser stage. It covers a one-byte load, a run with the done pin disabled, a polling timeout and a refused partial request whose pins must not move. It also checks that `s_ready` never rises mid-byte, since a design that did so would drop or overwrite stream bytes.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CS_SETUP,
    ST_RST_LOW,
    ST_SETTLE,
    ST_DATA,
    ST_TRAIL,
    ST_POLL,
    ST_USER
  } cfg_state_e;
endpackage

// File: rtl/cfg_sync.sv
// Multi-stage synchroniser for an asynchronous level input.
module cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] r_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_q <= '0;
    else        r_q <= {r_q[STAGES-2:0], d};
  end

  assign q = r_q[STAGES-1];
endmodule

// File: rtl/cfg_cycle_ctr.sv
// Free-running cycle counter with synchronous clear and enable.
module cfg_cycle_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cfg_bit_shifter.sv
// Byte serialiser, SPI mode 3, MSB first. Clock idles high; data moves
// only together with a falling clock; each phase lasts HALF_DIV cycles.
module cfg_bit_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic [7:0] din,
  output logic       rdy,
  output logic       sclk,
  output logic       mosi
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [7:0]       sh_q, sh_d;
  logic [2:0]       bit_q, bit_d;
  logic             ph_q, ph_d;
  logic             act_q, act_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             half_end;

  assign half_end = (div_q == DIV_W'(HALF_DIV - 1));

  always_comb begin
    sh_d  = sh_q;
    bit_d = bit_q;
    ph_d  = ph_q;
    act_d = act_q;
    div_d = div_q;
    if (!act_q) begin
      if (ld) begin
        sh_d  = din;
        bit_d = 3'd0;
        ph_d  = 1'b0;
        div_d = '0;
        act_d = 1'b1;
      end
    end else if (half_end) begin
      div_d = '0;
      if (!ph_q) begin
        ph_d = 1'b1;
      end else if (bit_q == 3'd7) begin
        act_d = 1'b0;              // keep last bit on the wire while idle
      end else begin
        bit_d = bit_q + 3'd1;
        sh_d  = {sh_q[6:0], 1'b0};
        ph_d  = 1'b0;
      end
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= 8'h00;
      bit_q <= 3'd0;
      ph_q  <= 1'b1;
      act_q <= 1'b0;
      div_q <= '0;
    end else begin
      sh_q  <= sh_d;
      bit_q <= bit_d;
      ph_q  <= ph_d;
      act_q <= act_d;
      div_q <= div_d;
    end
  end

  assign rdy  = !act_q;
  assign sclk = !act_q | ph_q;
  assign mosi = sh_q[7];
endmodule

// File: rtl/spi_cfg_loader.sv
// Passive serial configuration sequencer (top).
module spi_cfg_loader
  import spi_cfg_pkg::*;
#(
  parameter int HALF_DIV    = 2,
  parameter int RST_LOW_CYC = 64,
  parameter int SETTLE_CYC  = 6400,
  parameter int USER_CYC    = 5000,
  parameter int IDLE_BYTES  = 13,
  parameter int CNT_W       = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             partial_req,
  input  logic             done_en,
  input  logic [CNT_W-1:0] timeout_lim,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  input  logic             s_last,
  output logic             s_ready,
  output logic             cs_n,
  output logic             creset_n,
  output logic             sclk,
  output logic             mosi,
  input  logic             cdone_i,
  output logic             busy,
  output logic             done,
  output logic             err_timeout,
  output logic             err_refused,
  output logic             tgt_operating
);
  localparam int TB_W = $clog2(IDLE_BYTES + 1);

  cfg_state_e       state_q, state_d;
  logic             last_q, last_d;
  logic [TB_W-1:0]  tb_q, tb_d;
  logic             done_q, done_d;
  logic             eto_q, eto_d;
  logic             erf_q, erf_d;
  logic             cs_n_q, crst_n_q;
  logic             cdone_s;
  logic [CNT_W-1:0] cnt;
  logic             sh_ld, sh_rdy;
  logic [7:0]       sh_din;

  cfg_sync #(.STAGES(2)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(cdone_i), .q(cdone_s)
  );

  cfg_cycle_ctr #(.W(CNT_W)) i_ctr (
    .clk(clk), .rst_n(rst_n), .clr(state_d != state_q), .en(1'b1), .cnt(cnt)
  );

  cfg_bit_shifter #(.HALF_DIV(HALF_DIV)) i_shift (
    .clk(clk), .rst_n(rst_n), .ld(sh_ld), .din(sh_din),
    .rdy(sh_rdy), .sclk(sclk), .mosi(mosi)
  );

  assign s_ready = (state_q == ST_DATA) && sh_rdy && !last_q;

  always_comb begin
    state_d = state_q;
    last_d  = last_q;
    tb_d    = tb_q;
    done_d  = done_q;
    eto_d   = eto_q;
    erf_d   = erf_q;
    sh_ld   = 1'b0;
    sh_din  = s_data;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          done_d = 1'b0;
          eto_d  = 1'b0;
          erf_d  = partial_req;
          if (!partial_req) begin
            state_d = ST_CS_SETUP;
            last_d  = 1'b0;
            tb_d    = '0;
          end
        end
      end
      ST_CS_SETUP: state_d = ST_RST_LOW;
      ST_RST_LOW:
        if (cnt == CNT_W'(RST_LOW_CYC - 1)) state_d = ST_SETTLE;
      ST_SETTLE:
        if (cnt == CNT_W'(SETTLE_CYC - 1)) state_d = ST_DATA;
      ST_DATA: begin
        if (s_valid && s_ready) begin
          sh_ld = 1'b1;
          if (s_last) last_d = 1'b1;
        end else if (last_q && sh_rdy) begin
          state_d = ST_TRAIL;
        end
      end
      ST_TRAIL: begin
        sh_din = 8'h00;
        if (sh_rdy) begin
          if (tb_q == TB_W'(IDLE_BYTES)) begin
            state_d = done_en ? ST_POLL : ST_USER;
          end else begin
            sh_ld = 1'b1;
            tb_d  = tb_q + 1'b1;
          end
        end
      end
      ST_POLL: begin
        if (cdone_s) begin
          state_d = ST_USER;
        end else if (cnt == timeout_lim) begin
          eto_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_USER: begin
        if (cnt == CNT_W'(USER_CYC - 1)) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      last_q   <= 1'b0;
      tb_q     <= '0;
      done_q   <= 1'b0;
      eto_q    <= 1'b0;
      erf_q    <= 1'b0;
      cs_n_q   <= 1'b1;
      crst_n_q <= 1'b1;
    end else begin
      state_q  <= state_d;
      last_q   <= last_d;
      tb_q     <= tb_d;
      done_q   <= done_d;
      eto_q    <= eto_d;
      erf_q    <= erf_d;
      cs_n_q   <= (state_d == ST_IDLE);
      crst_n_q <= (state_d != ST_RST_LOW);
    end
  end

  assign cs_n          = cs_n_q;
  assign creset_n      = crst_n_q;
  assign busy          = (state_q != ST_IDLE);
  assign done          = done_q;
  assign err_timeout   = eto_q;
  assign err_refused   = erf_q;
  assign tgt_operating = done_en && cdone_s;
endmodule

// File: rtl/spi_cfg_loader_chk.sv
// Protocol checker attached to every instance of the sequencer.
module spi_cfg_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic partial_req,
  input logic done_en,
  input logic s_ready,
  input logic cs_n,
  input logic creset_n,
  input logic sclk,
  input logic mosi,
  input logic busy,
  input logic done,
  input logic err_timeout,
  input logic err_refused,
  input logic tgt_operating
);
  p_cs_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n);

  p_cs_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(creset_n) |-> (!cs_n && !$past(cs_n)));

  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  p_ready_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (sclk && busy));

  p_refuse_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && partial_req && !busy) |=> (cs_n && creset_n && err_refused && !busy));

  p_oper_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_operating |-> done_en);

  p_status_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!err_timeout && !err_refused));
endmodule

bind spi_cfg_loader spi_cfg_loader_chk i_chk (.*);

// File: tb/test_spi_cfg_loader.sv
module test_spi_cfg_loader;
  localparam int HALF_DIV = 2;
  localparam int RST_LOW  = 5;
  localparam int SETTLE   = 12;
  localparam int USER     = 9;
  localparam int TAIL     = 13;
  localparam int CW       = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, partial_req = 1'b0, done_en = 1'b0;
  logic [CW-1:0] timeout_lim = 16'd1000;
  logic [7:0] s_data = 8'h00;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic cdone_i = 1'b0;
  logic s_ready, cs_n, creset_n, sclk, mosi;
  logic busy, done, err_timeout, err_refused, tgt_operating;

  int vectors = 0, miscompares = 0;

  always #2.5 clk = ~clk;

  spi_cfg_loader #(
    .HALF_DIV(HALF_DIV), .RST_LOW_CYC(RST_LOW), .SETTLE_CYC(SETTLE),
    .USER_CYC(USER), .IDLE_BYTES(TAIL), .CNT_W(CW)
  ) i_spi_cfg_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .partial_req(partial_req),
    .done_en(done_en), .timeout_lim(timeout_lim), .s_data(s_data),
    .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready), .cs_n(cs_n),
    .creset_n(creset_n), .sclk(sclk), .mosi(mosi), .cdone_i(cdone_i),
    .busy(busy), .done(done), .err_timeout(err_timeout),
    .err_refused(err_refused), .tgt_operating(tgt_operating)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard: expected serial bytes, popped by the monitor.
  logic [7:0] expq[$];
  logic [7:0] rx_sh = 8'h00;
  int rx_bits = 0, rx_bytes = 0, rise_cnt = 0;
  int low_cnt = 0, low_width = 0, settle_cnt = 0, settle_gap = 0;
  bit settle_arm = 1'b0, lead_ok = 1'b1;
  int rdy_viol = 0;
  logic p_sclk = 1'b1, p_crst = 1'b1, p_cs = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n && sclk && !p_sclk) begin
        rx_sh = {rx_sh[6:0], mosi};
        rx_bits++;
        rise_cnt++;
        if (rx_bits == 8) begin
          rx_bits = 0;
          rx_bytes++;
          if (expq.size() == 0) begin
            check(1'b0, "R5 unexpected byte", int'(rx_sh), -1);
          end else begin
            logic [7:0] e;
            e = expq.pop_front();
            check(rx_sh == e, "R5/R7 serial byte", int'(rx_sh), int'(e));
          end
        end
      end
      if (!creset_n) low_cnt++;
      if (!creset_n && p_crst) lead_ok = !cs_n && !p_cs;
      if (creset_n && !p_crst) begin
        low_width  = low_cnt;
        low_cnt    = 0;
        settle_cnt = 0;
        settle_arm = 1'b1;
      end else if (settle_arm) begin
        settle_cnt++;
        if (!sclk && p_sclk) begin
          settle_gap = settle_cnt;
          settle_arm = 1'b0;
        end
      end
      if (s_ready && !sclk) rdy_viol++;
    end
    p_sclk = sclk;
    p_crst = creset_n;
    p_cs   = cs_n;
  end

  task automatic begin_run(input int n, input int seed, input bit use_done);
    rise_cnt = 0;
    rx_bytes = 0;
    rx_bits  = 0;
    for (int i = 0; i < n; i++) expq.push_back(8'((seed + i * 37) & 255));
    for (int i = 0; i < TAIL; i++) expq.push_back(8'h00);
    done_en = use_done;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic stream(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      s_data  = 8'((seed + i * 37) & 255);
      s_valid = 1'b1;
      s_last  = (i == n - 1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
    while (rx_bytes < n + TAIL) @(negedge clk);
  endtask

  task automatic shape_checks(input int n);
    check(rx_bytes == n + TAIL, "R5 byte count", rx_bytes, n + TAIL);
    check(rise_cnt == 8 * (n + TAIL), "R7 rising clocks", rise_cnt, 8 * (n + TAIL));
    check(low_width == RST_LOW, "R2 reset width", low_width, RST_LOW);
    check(lead_ok, "R2 cs before reset", int'(lead_ok), 1);
    check(settle_gap >= SETTLE, "R3 settle gap", settle_gap, SETTLE);
    check(rdy_viol == 0, "R6 ready while shifting", rdy_viol, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R13: reset state
    check(cs_n && creset_n && sclk, "R13 reset pins", int'({cs_n, creset_n, sclk}), 7);
    check(!busy && !done && !s_ready, "R13 reset status", int'({busy, done, s_ready}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Run A: five bytes, done pin polled
    begin_run(5, 8'hA5, 1'b1);
    check(busy && !cs_n, "R13/R1 start raises busy", int'({busy, cs_n}), 2);
    stream(5, 8'hA5);
    repeat (4) @(negedge clk);
    check(busy && !done && !cs_n, "R1 held while polling", int'({busy, done, cs_n}), 4);
    cdone_i = 1'b1;
    cyc = 0;
    while (!done) begin @(negedge clk); cyc++; end
    check(cyc == USER + 3, "R9 user-mode delay", cyc, USER + 3);
    check(cs_n && !busy, "R1 release on completion", int'({cs_n, busy}), 2);
    check(tgt_operating, "R12 operating with done", int'(tgt_operating), 1);
    shape_checks(5);
    cdone_i = 1'b0;
    repeat (3) @(negedge clk);
    check(!tgt_operating, "R12 unknown after drop", int'(tgt_operating), 0);

    // Run B: three bytes, done pin disabled
    begin_run(3, 8'h12, 1'b0);
    check(!done && busy, "R13 start clears done", int'({done, busy}), 1);
    stream(3, 8'h12);
    cyc = 0;
    while (!done && cyc < 100) begin @(negedge clk); cyc++; end
    check(done && cyc >= USER && cyc <= USER + HALF_DIV + 3, "R11 skip polling", cyc, USER);
    shape_checks(3);
    cdone_i = 1'b1;
    repeat (4) @(negedge clk);
    check(!tgt_operating, "R12 gated by done_en", int'(tgt_operating), 0);
    cdone_i = 1'b0;
    repeat (3) @(negedge clk);

    // Run C: polling timeout
    timeout_lim = 16'd20;
    begin_run(2, 8'h5A, 1'b1);
    stream(2, 8'h5A);
    cyc = 0;
    while (busy && cyc < 200) begin @(negedge clk); cyc++; end
    check(err_timeout && !done, "R8 timeout flagged", int'({err_timeout, done}), 2);
    check(cyc >= 21 && cyc <= 21 + HALF_DIV + 4, "R8 timeout length", cyc, 21);
    check(cs_n && !busy, "R1 release on error", int'({cs_n, busy}), 2);
    timeout_lim = 16'd1000;

    // Run D: refused partial request
    begin
      int chg;
      chg = 0;
      partial_req = 1'b1;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      partial_req = 1'b0;
      for (int k = 0; k < 30; k++) begin
        if (!cs_n || !creset_n || !sclk || busy) chg++;
        @(negedge clk);
      end
      check(chg == 0, "R10 pins quiet", chg, 0);
      check(err_refused && !err_timeout, "R10 refused flag", int'({err_refused, err_timeout}), 2);
    end

    // Run E: single byte marked last, done already high
    cdone_i = 1'b1;
    repeat (3) @(negedge clk);
    begin_run(1, 8'hC3, 1'b1);
    check(!err_refused, "R13 start clears errors", int'(err_refused), 0);
    stream(1, 8'hC3);
    cyc = 0;
    while (!done && cyc < 100) begin @(negedge clk); cyc++; end
    check(done, "R5 single byte load completes", int'(done), 1);
    shape_checks(1);
    check(expq.size() == 0, "R7 tail fully sent", expq.size(), 0);
    cdone_i = 1'b0;
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule